// File: doc/BRIEF.md
# DRAM Self-Refresh Entry/Exit Sequencer

This block takes a DRAM into its low-power self-refresh mode and back out again. A one-cycle sleep request, accepted while the block is ready, makes it issue the refresh command code. In that same cycle clock enable is pulled low. The memory is then held in self-refresh with clock enable low and only no-operation codes on the command bus. While in this mode the command input from the rest of the controller is ignored.

A wake request, accepted only while parked in self-refresh, starts the exit. The block keeps clock enable low until the clock is reported stable, then raises it. For the exit recovery window it drives only no-operation codes. When that window ends, `ready` goes high and general commands pass through. Reads are still replaced by no-operation codes until the memory's DLL has had its relock cycles, counted from the rise of clock enable. At that point `rd_allow` goes high.

The exit recovery length and the DLL relock length are parameters. If the recovery window is at least as long as the relock window, the read-blocking phase is dropped and both flags rise together.

Top module: `selfref_seq`

## Requirements
- R1: While reset is held, `cke` is 1, `cmd_out` is NOP (3'b111), and `ready` and `rd_allow` are 0. In the first cycle after reset is released the outputs are the same. From the second cycle on, the block is ready.
- R2: In the ready state, `cke` is 1, `ready` and `rd_allow` are 1, and `cmd_out` equals `cmd_in` in the same cycle.
- R3: A `sleep_req` sampled in the ready state causes one cycle with `cmd_out` = refresh code 3'b001 and `cke` = 0. The cycle after that shows NOP with `cke` still 0.
- R4: While parked in self-refresh, `cke` is 0, `cmd_out` is NOP whatever `cmd_in` holds, and `ready` and `rd_allow` are 0.
- R5: A `sleep_req` outside the ready state and a `wake_req` outside the parked self-refresh state change nothing. This includes the refresh-command cycle and the wait for a stable clock.
- R6: After an accepted wake, `cke` stays 0 with NOP on the bus until `clk_stable` is sampled high. `cke` rises in the cycle after that sample.
- R7: For the first `TXSNR` cycles with `cke` high after an exit, `cmd_out` is NOP and `ready` is 0.
- R8: From cycle `TXSNR` until cycle `DLL_CYC` after the rise of `cke`, `ready` is 1 and `rd_allow` is 0. In that window `cmd_in` passes through, except that the read code 3'b101 is replaced by NOP.
- R9: `rd_allow` rises exactly `DLL_CYC` cycles after `cke` rises on exit and is never high earlier.
- R10: When `TXSNR` >= `DLL_CYC`, `ready` and `rd_allow` both rise `TXSNR` cycles after `cke` rises, with no read-blocking phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter self-refresh |
| wake_req | input | 1 | One-cycle request to leave self-refresh |
| clk_stable | input | 1 | High when the memory clock is stable |
| cmd_in | input | 3 | Command code from the controller ({ras_n, cas_n, we_n}) |
| cke | output | 1 | Clock enable to the memory |
| cmd_out | output | 3 | Command code sent to the memory |
| ready | output | 1 | General commands may be issued |
| rd_allow | output | 1 | Read commands may be issued |

## Verification
The assertions assume that `clk_stable` and the requests are synchronous to `clk` and held steady around each edge. They also assume `cmd_in` is a 3-bit code in which only 3'b101 means read and 3'b001 means refresh. The stimulus changes every input only on the falling edge. It draws requests at random, so sleep and wake pulses often land in states where they must be ignored. It also keeps `clk_stable` low for random stretches, including a long directed one right after a wake. A second instance with recovery longer than relock runs on the same inputs, so the variant that skips the read-blocking phase sees the same request patterns.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

   localparam int CMD_W = 3;

   // {ras_n, cas_n, we_n}
   localparam logic [CMD_W-1:0] CMD_NOP     = 3'b111;
   localparam logic [CMD_W-1:0] CMD_READ    = 3'b101;
   localparam logic [CMD_W-1:0] CMD_REFRESH = 3'b001;

   typedef enum logic [6:0] {
      ST_IDLE     = 7'b000_0001,
      ST_READY    = 7'b000_0010,
      ST_ENTER    = 7'b000_0100,
      ST_IN_SR    = 7'b000_1000,
      ST_WAIT_CLK = 7'b001_0000,
      ST_EXIT_NOP = 7'b010_0000,
      ST_DLL_WAIT = 7'b100_0000
   } sr_state_t;

endpackage

// File: rtl/selfref_timer.sv
module selfref_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/selfref_fsm.sv
module selfref_fsm
   import selfref_pkg::*;
#(
   parameter int TXSNR   = 10,
   parameter int DLL_CYC = 200,
   parameter int CNT_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             wake_req,
   input  logic             clk_stable,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output sr_state_t        state
);

   localparam bit SKIP_DLL = (TXSNR >= DLL_CYC);
   localparam int DLL_REM  = SKIP_DLL ? 0 : (DLL_CYC - TXSNR - 1);
   localparam logic [CNT_W-1:0] XS_LOAD  = CNT_W'(TXSNR - 1);
   localparam logic [CNT_W-1:0] DLL_LOAD = CNT_W'(DLL_REM);

   sr_state_t nxt;
   sr_state_t after_exit;
   logic      exit_load;

   generate
      if (SKIP_DLL) begin : g_no_dll
         assign after_exit = ST_READY;
         assign exit_load  = 1'b0;
      end else begin : g_dll
         assign after_exit = ST_DLL_WAIT;
         assign exit_load  = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         ST_IDLE:     nxt = ST_READY;
         ST_READY:    if (sleep_req) nxt = ST_ENTER;
         ST_ENTER:    nxt = ST_IN_SR;
         ST_IN_SR:    if (wake_req) nxt = ST_WAIT_CLK;
         ST_WAIT_CLK: if (clk_stable) begin
            nxt      = ST_EXIT_NOP;
            tmr_load = 1'b1;
            tmr_val  = XS_LOAD;
         end
         ST_EXIT_NOP: if (tmr_zero) begin
            nxt      = after_exit;
            tmr_load = exit_load;
            tmr_val  = DLL_LOAD;
         end
         ST_DLL_WAIT: if (tmr_zero) nxt = ST_READY;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R5: a parked memory stays parked without a wake request
   assert_park_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IN_SR && !wake_req) |=> (state == ST_IN_SR));

   // R5: ready state is left only on a sleep request
   assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && !sleep_req) |=> (state == ST_READY));

   // R6: exit waits in place while the clock is unstable
   assert_wait_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_CLK && !clk_stable) |=> (state == ST_WAIT_CLK));

endmodule

// File: rtl/selfref_cmd_gate.sv
module selfref_cmd_gate
   import selfref_pkg::*;
(
   input  sr_state_t        state,
   input  logic [CMD_W-1:0] cmd_in,
   output logic             cke,
   output logic [CMD_W-1:0] cmd_out,
   output logic             ready,
   output logic             rd_allow
);

   always_comb begin
      cke      = 1'b1;
      cmd_out  = CMD_NOP;
      ready    = 1'b0;
      rd_allow = 1'b0;
      case (state)
         ST_READY: begin
            cmd_out  = cmd_in;
            ready    = 1'b1;
            rd_allow = 1'b1;
         end
         ST_ENTER: begin
            cke     = 1'b0;
            cmd_out = CMD_REFRESH;
         end
         ST_IN_SR, ST_WAIT_CLK: cke = 1'b0;
         ST_DLL_WAIT: begin
            ready   = 1'b1;
            cmd_out = (cmd_in == CMD_READ) ? CMD_NOP : cmd_in;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/selfref_seq.sv
module selfref_seq
   import selfref_pkg::*;
#(
   parameter int TXSNR   = 10,
   parameter int DLL_CYC = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_req,
   input  logic       wake_req,
   input  logic       clk_stable,
   input  logic [2:0] cmd_in,
   output logic       cke,
   output logic [2:0] cmd_out,
   output logic       ready,
   output logic       rd_allow
);

   localparam int CNT_MAX = (TXSNR > DLL_CYC) ? TXSNR : DLL_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (TXSNR < 1) begin : g_bad_txsnr
         $error("selfref_seq: TXSNR must be at least 1");
      end
      if (DLL_CYC < 1) begin : g_bad_dll
         $error("selfref_seq: DLL_CYC must be at least 1");
      end
   endgenerate

   sr_state_t        state;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;

   selfref_fsm #(
      .TXSNR   (TXSNR),
      .DLL_CYC (DLL_CYC),
      .CNT_W   (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .wake_req   (wake_req),
      .clk_stable (clk_stable),
      .tmr_zero   (tmr_zero),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .state      (state)
   );

   selfref_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   selfref_cmd_gate u_gate (
      .state    (state),
      .cmd_in   (cmd_in),
      .cke      (cke),
      .cmd_out  (cmd_out),
      .ready    (ready),
      .rd_allow (rd_allow)
   );

   // R3: accepted sleep gives the refresh code with cke low
   assert_enter_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && sleep_req) |=> (!cke && cmd_out == CMD_REFRESH));

   // R4: with cke low only NOP or the entry refresh code appear
   assert_cke_low_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (cmd_out == CMD_NOP || cmd_out == CMD_REFRESH));

   // R6: cke rises only after a stable-clock sample
   assert_cke_rise_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> $past(clk_stable));

   // R7: first cycle after cke rises is NOP and not ready
   assert_exit_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (!ready && cmd_out == CMD_NOP));

   // R8: no read leaves while reads are blocked
   assert_no_early_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_allow |-> (cmd_out != CMD_READ));

   // R9: read permission implies general readiness
   assert_rd_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_allow |-> ready);

endmodule

// File: tb/test_selfref_seq.sv
module selfref_model #(
   parameter int TXSNR   = 10,
   parameter int DLL_CYC = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep,
   input  logic       wake,
   input  logic       stable,
   input  logic [2:0] cmd_in,
   output int         ph,
   output logic       ign,
   output logic       e_cke,
   output logic [2:0] e_cmd,
   output logic       e_ready,
   output logic       e_rd
);
   // phases: 0 reset/idle, 1 ready, 2 refresh cycle, 3 parked,
   //         4 clock wait, 5 recovery, 6 relock
   int since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= 0; since <= 0; ign <= 1'b0;
      end else begin
         ign <= (sleep && ph != 1) || (wake && ph != 3);
         case (ph)
            0: ph <= 1;
            1: if (sleep) ph <= 2;
            2: ph <= 3;
            3: if (wake) ph <= 4;
            4: if (stable) begin ph <= 5; since <= 0; end
            5: begin
               since <= since + 1;
               if (since + 1 == TXSNR) ph <= (TXSNR >= DLL_CYC) ? 1 : 6;
            end
            6: begin
               since <= since + 1;
               if (since + 1 == DLL_CYC) ph <= 1;
            end
            default: ph <= 0;
         endcase
      end
   end

   always_comb begin
      e_cke   = !(ph == 2 || ph == 3 || ph == 4);
      e_ready = (ph == 1 || ph == 6);
      e_rd    = (ph == 1);
      case (ph)
         1:       e_cmd = cmd_in;
         2:       e_cmd = 3'b001;
         6:       e_cmd = (cmd_in == 3'b101) ? 3'b111 : cmd_in;
         default: e_cmd = 3'b111;
      endcase
   end
endmodule

module test_selfref_seq;
   localparam int CLK_PERIOD = 10;
   localparam int TX_A = 10, DL_A = 200;
   localparam int TX_B = 8,  DL_B = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b0;
   logic [2:0] cmd_in = 3'b111;

   logic a_cke, a_ready, a_rd; logic [2:0] a_cmd;
   logic b_cke, b_ready, b_rd; logic [2:0] b_cmd;
   int   pa, pb; logic ia, ib;
   logic ea_cke, ea_ready, ea_rd; logic [2:0] ea_cmd;
   logic eb_cke, eb_ready, eb_rd; logic [2:0] eb_cmd;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   selfref_seq #(.TXSNR(TX_A), .DLL_CYC(DL_A)) i_selfref_seq (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .clk_stable(clk_stable), .cmd_in(cmd_in), .cke(a_cke), .cmd_out(a_cmd),
      .ready(a_ready), .rd_allow(a_rd));

   selfref_seq #(.TXSNR(TX_B), .DLL_CYC(DL_B)) i_selfref_seq_skip (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
      .clk_stable(clk_stable), .cmd_in(cmd_in), .cke(b_cke), .cmd_out(b_cmd),
      .ready(b_ready), .rd_allow(b_rd));

   selfref_model #(.TXSNR(TX_A), .DLL_CYC(DL_A)) m_a (
      .clk(clk), .rst_n(rst_n), .sleep(sleep_req), .wake(wake_req),
      .stable(clk_stable), .cmd_in(cmd_in), .ph(pa), .ign(ia), .e_cke(ea_cke),
      .e_cmd(ea_cmd), .e_ready(ea_ready), .e_rd(ea_rd));

   selfref_model #(.TXSNR(TX_B), .DLL_CYC(DL_B)) m_b (
      .clk(clk), .rst_n(rst_n), .sleep(sleep_req), .wake(wake_req),
      .stable(clk_stable), .cmd_in(cmd_in), .ph(pb), .ign(ib), .e_cke(eb_cke),
      .e_cmd(eb_cmd), .e_ready(eb_ready), .e_rd(eb_rd));

   function automatic string req_of(int ph, logic ign, bit skip);
      if (ign) return "R5";
      case (ph)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R6";
         5: return skip ? "R10" : "R7";
         6: return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_pair(input string inst, input int ph, input logic ign, input bit skip,
                               input logic c, input logic ec, input logic [2:0] m,
                               input logic [2:0] em, input logic r, input logic er,
                               input logic d, input logic ed);
      string rq;
      rq = req_of(ph, ign, skip);
      check(c === ec, rq, {inst, " cke"}, int'(c), int'(ec));
      check(m === em, rq, {inst, " cmd_out"}, int'(m), int'(em));
      check(r === er, rq, {inst, " ready"}, int'(r), int'(er));
      // R9 / R10: read permission timing
      check(d === ed, skip ? "R10" : "R9", {inst, " rd_allow"}, int'(d), int'(ed));
   endtask

   task automatic compare_all();
      compare_pair("A", pa, ia, 1'b0, a_cke, ea_cke, a_cmd, ea_cmd, a_ready, ea_ready, a_rd, ea_rd);
      compare_pair("B", pb, ib, 1'b1, b_cke, eb_cke, b_cmd, eb_cmd, b_ready, eb_ready, b_rd, eb_rd);
   endtask

   task automatic cyc(input logic s, input logic w, input logic st, input logic [2:0] c);
      @(negedge clk);
      sleep_req = s; wake_req = w; clk_stable = st; cmd_in = c;
      #1;
      compare_all();
   endtask

   function automatic logic [2:0] rnd_cmd();
      if ($urandom % 3 == 0) return 3'b101;
      return 3'($urandom % 8);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0417));
      // R1: outputs under reset
      repeat (3) @(negedge clk);
      cmd_in = 3'b101;
      #1;
      check(a_cke === 1'b1 && a_cmd === 3'b111, "R1", "reset cke/cmd", int'({a_cke, a_cmd}), 15);
      check(a_ready === 1'b0 && a_rd === 1'b0, "R1", "reset flags", int'({a_ready, a_rd}), 0);
      compare_all();
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare_all();

      // R2: pass-through in ready, then R5: wake in ready ignored
      cyc(0, 0, 1, 3'b101);
      cyc(0, 0, 1, 3'b011);
      cyc(0, 1, 1, 3'b101);
      cyc(0, 0, 1, 3'b100);
      // R3: accepted sleep
      cyc(1, 0, 1, 3'b101);
      cyc(1, 1, 1, 3'b101);          // wake during refresh cycle: R5
      for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'($urandom), rnd_cmd()); // R4, R5
      // R6: wake with an unstable clock held for a long stretch
      cyc(0, 1, 0, 3'b101);
      for (int i = 0; i < 20; i++) cyc(1'b0, 1'($urandom), 1'b0, rnd_cmd());
      cyc(0, 0, 1, 3'b101);
      // R7 .. R9: recovery, relock, read release
      for (int i = 0; i < DL_A + 10; i++) cyc(1'b0, 1'($urandom), 1'b0, rnd_cmd());

      // random mixture
      for (int i = 0; i < 3000; i++)
         cyc(1'($urandom % 8 == 0), 1'($urandom % 6 == 0), 1'($urandom % 3 != 0), rnd_cmd());

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule